// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block produces the system reset for a small 8-bit controller core. It runs on the oscillator clock and divides it into machine cycles. All of its timing is counted in machine cycles, and its outputs change only at machine-cycle boundaries. The block merges three reset sources:

- a level sampled from the bidirectional reset pin, which must be qualified before it counts;
- a watchdog overflow pulse;
- a wake-up event from the CAN controller, which is accepted only while the chip is in power-down.

Each internal source is stretched into a fixed-length window. While a window is open, the block asks the pin pad to drive the line high. The core reset covers all three sources. A separate reset for the CAN controller ignores the wake-up window, so a wake-up resets the core without losing the controller's state. Two force-high levels keep the address-latch and program-fetch strobes high during core reset. A small cause code tells software which source acted last.

Top module: `rsq_reset_seq`

## Requirements
- R1: A machine cycle is OSC_PER_MC (12) oscillator clocks. `mc_tick` is high for one clock in every 12. Its first high clock is the 12th clock after power-on release. Every machine-cycle boundary is the clock edge at which `mc_tick` is sampled high.
- R2: From power-on (`pwr_rst_n` low) until the first machine-cycle boundary, `core_rst` and `can_rst` are high and `rst_cause` is 2'b00. They are then released if no source is active.
- R3: The pin level passes through a two-flop synchronizer and is sampled once per machine cycle, at the boundary. An external reset is accepted once two consecutive samples are high. A low sample restarts the qualification, so a high level that spans only one sample causes no reset.
- R4: A one-clock `wdt_ovf` pulse opens a watchdog window at the next boundary. During the window `rst_pin_drive` is high for exactly 3 machine cycles (36 clocks).
- R5: A `can_wake` pulse while `pwr_down` is high opens a wake window of exactly 6144 machine cycles of `rst_pin_drive`. A `can_wake` pulse while `pwr_down` is low has no effect.
- R6: `can_rst` follows the accepted external reset and the watchdog window, and is not raised by the wake window. A watchdog window alone holds `can_rst` for 4 machine cycles (48 clocks).
- R7: `core_rst` is high while any source is active, whatever the sampled pin level. It is released one machine cycle after the last source ends.
- R8: Each window is reloaded to its full length by a new event and is never shortened. A watchdog window that opens inside a wake window does not change the wake window's length.
- R9: `ale_hold` and `psen_hold` are high exactly while `core_rst` is high.
- R10: `rst_cause` encodes the most recent source: 2'b01 external, 2'b10 watchdog, 2'b11 wake-up. It keeps its value after release. When sources start at the same boundary, wake-up takes priority over watchdog, and watchdog over external.
- R11: `core_rst`, `can_rst`, `rst_pin_drive` and `rst_cause` change only at machine-cycle boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| pwr_rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_in | input | 1 | Level sampled on the reset pin |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| can_wake | input | 1 | CAN wake-up event pulse |
| pwr_down | input | 1 | Chip is in power-down |
| mc_tick | output | 1 | Last oscillator clock of a machine cycle |
| rst_pin_drive | output | 1 | Enable for the pull-up that drives the pin high |
| core_rst | output | 1 | Core reset, active high |
| can_rst | output | 1 | CAN controller reset, active high |
| ale_hold | output | 1 | Force address-latch strobe high |
| psen_hold | output | 1 | Force program-fetch strobe high |
| rst_cause | output | 2 | Code of the most recent reset source |

## Verification
The properties assume that `wdt_ovf` and `can_wake` arrive at any clock, and that `pwr_down` and the pin level change freely. They assume that `pwr_rst_n` is asserted only at power-up, so that every window measured after release starts from an idle block. The stimulus drives inputs between clock edges. It applies power-on reset once, and spaces events so that each measured window opens from an idle state, except for the deliberate watchdog overlap inside the wake window. Pin pulses are kept either shorter than one machine cycle or longer than three, so that each pulse falls clearly on one side of the qualification threshold.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   typedef enum logic [1:0] {
      CAUSE_NONE = 2'b00,
      CAUSE_EXT  = 2'b01,
      CAUSE_WDT  = 2'b10,
      CAUSE_WAKE = 2'b11
   } rsq_cause_e;
endpackage

// File: rtl/rsq_mc_divider.sv
module rsq_mc_divider #(
   parameter int OSC_PER_MC = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int DW = (OSC_PER_MC > 2) ? $clog2(OSC_PER_MC) : 1;
   localparam logic [DW-1:0] LAST = DW'(OSC_PER_MC - 1);

   logic [DW-1:0] div_q;

   generate
      if (OSC_PER_MC < 2) begin : g_bad
         $error("rsq_mc_divider: OSC_PER_MC must be at least 2");
      end
   endgenerate

   assign tick = (div_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (tick) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/rsq_pin_qualifier.sv
module rsq_pin_qualifier #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_MC     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin,
   output logic ext_ok,
   output logic ext_nxt
);
   localparam int QW = $clog2(QUAL_MC + 1);
   localparam logic [QW-1:0] QMAX = QW'(QUAL_MC);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic [QW-1:0]          qual_q, qual_nxt;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rsq_pin_qualifier: SYNC_STAGES must be at least 2");
      end
      if (QUAL_MC < 1) begin : g_bad_qual
         $error("rsq_pin_qualifier: QUAL_MC must be at least 1");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_comb begin
      qual_nxt = qual_q;
      if (tick) begin
         if (!pin_s)             qual_nxt = '0;
         else if (qual_q != QMAX) qual_nxt = qual_q + 1'b1;
      end
   end

   assign ext_nxt = (qual_nxt == QMAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_q <= '0;
         ext_ok <= 1'b0;
      end else begin
         qual_q <= qual_nxt;
         ext_ok <= ext_nxt;
      end
   end
endmodule

// File: rtl/rsq_pulse_timer.sv
module rsq_pulse_timer #(
   parameter int LEN_MC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fire,
   output logic active,
   output logic active_nxt,
   output logic load
);
   localparam int CW = $clog2(LEN_MC + 1);
   localparam logic [CW-1:0] FULL = CW'(LEN_MC);

   logic          pend_q;
   logic          fire_eff;
   logic [CW-1:0] cnt_q, cnt_dec, cnt_nxt;

   generate
      if (LEN_MC < 1) begin : g_bad
         $error("rsq_pulse_timer: LEN_MC must be at least 1");
      end
   endgenerate

   assign fire_eff = fire | pend_q;
   assign cnt_dec  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
   assign load     = tick & fire_eff;

   always_comb begin
      cnt_nxt = cnt_q;
      if (tick) cnt_nxt = fire_eff ? FULL : cnt_dec;
   end

   assign active     = (cnt_q != '0);
   assign active_nxt = (cnt_nxt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_nxt;
         pend_q <= tick ? 1'b0 : fire_eff;
      end
   end
endmodule

// File: rtl/rsq_release_stage.sv
module rsq_release_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic src_nxt,
   output logic rst_out
);
   logic tail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tail_q  <= 1'b0;
         rst_out <= 1'b1;
      end else if (tick) begin
         tail_q  <= src_nxt;
         rst_out <= src_nxt | tail_q;
      end
   end
endmodule

// File: rtl/rsq_reset_seq.sv
module rsq_reset_seq #(
   parameter int OSC_PER_MC  = 12,
   parameter int EXT_QUAL_MC = 2,
   parameter int WDT_MC      = 3,
   parameter int WAKE_MC     = 6144,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_osc,
   input  logic       pwr_rst_n,
   input  logic       rst_pin_in,
   input  logic       wdt_ovf,
   input  logic       can_wake,
   input  logic       pwr_down,
   output logic       mc_tick,
   output logic       rst_pin_drive,
   output logic       core_rst,
   output logic       can_rst,
   output logic       ale_hold,
   output logic       psen_hold,
   output logic [1:0] rst_cause
);
   import rsq_pkg::*;

   logic ext_ok, ext_nxt;
   logic wdt_act, wdt_act_nxt, wdt_load;
   logic wake_act, wake_act_nxt, wake_load;
   logic core_src_nxt, can_src_nxt;
   rsq_cause_e cause_q;

   generate
      if (WAKE_MC < WDT_MC) begin : g_bad_len
         $error("rsq_reset_seq: WAKE_MC shorter than WDT_MC");
      end
   endgenerate

   rsq_mc_divider #(.OSC_PER_MC(OSC_PER_MC)) u_div (
      .clk(clk_osc), .rst_n(pwr_rst_n), .tick(mc_tick)
   );

   rsq_pin_qualifier #(.SYNC_STAGES(SYNC_STAGES), .QUAL_MC(EXT_QUAL_MC)) u_pin (
      .clk(clk_osc), .rst_n(pwr_rst_n), .tick(mc_tick), .pin(rst_pin_in),
      .ext_ok(ext_ok), .ext_nxt(ext_nxt)
   );

   rsq_pulse_timer #(.LEN_MC(WDT_MC)) u_wdt (
      .clk(clk_osc), .rst_n(pwr_rst_n), .tick(mc_tick), .fire(wdt_ovf),
      .active(wdt_act), .active_nxt(wdt_act_nxt), .load(wdt_load)
   );

   rsq_pulse_timer #(.LEN_MC(WAKE_MC)) u_wake (
      .clk(clk_osc), .rst_n(pwr_rst_n), .tick(mc_tick), .fire(can_wake & pwr_down),
      .active(wake_act), .active_nxt(wake_act_nxt), .load(wake_load)
   );

   assign core_src_nxt = ext_nxt | wdt_act_nxt | wake_act_nxt;
   assign can_src_nxt  = ext_nxt | wdt_act_nxt;

   rsq_release_stage u_core_rel (
      .clk(clk_osc), .rst_n(pwr_rst_n), .tick(mc_tick),
      .src_nxt(core_src_nxt), .rst_out(core_rst)
   );

   rsq_release_stage u_can_rel (
      .clk(clk_osc), .rst_n(pwr_rst_n), .tick(mc_tick),
      .src_nxt(can_src_nxt), .rst_out(can_rst)
   );

   always_ff @(posedge clk_osc or negedge pwr_rst_n) begin
      if (!pwr_rst_n)                cause_q <= CAUSE_NONE;
      else if (wake_load)            cause_q <= CAUSE_WAKE;
      else if (wdt_load)             cause_q <= CAUSE_WDT;
      else if (mc_tick && ext_nxt && !ext_ok) cause_q <= CAUSE_EXT;
   end

   assign rst_cause     = cause_q;
   assign rst_pin_drive = wdt_act | wake_act;
   assign ale_hold      = core_rst;
   assign psen_hold     = core_rst;
endmodule

// File: rtl/rsq_reset_seq_chk.sv
module rsq_reset_seq_chk #(
   parameter int WDT_MC = 3
) (
   input logic       clk_osc,
   input logic       pwr_rst_n,
   input logic       mc_tick,
   input logic       rst_pin_drive,
   input logic       core_rst,
   input logic       can_rst,
   input logic [1:0] rst_cause
);
   int unsigned drv_mc;

   always_ff @(posedge clk_osc or negedge pwr_rst_n) begin
      if (!pwr_rst_n)         drv_mc <= 0;
      else if (!rst_pin_drive) drv_mc <= 0;
      else if (mc_tick)        drv_mc <= drv_mc + 1;
   end

   // R1
   tick_single_chk: assert property (@(posedge clk_osc) disable iff (!pwr_rst_n)
      mc_tick |=> !mc_tick);

   // R11
   core_edge_chk: assert property (@(posedge clk_osc) disable iff (!pwr_rst_n)
      !$stable(core_rst) |-> $past(mc_tick));

   // R11
   cause_edge_chk: assert property (@(posedge clk_osc) disable iff (!pwr_rst_n)
      !$stable(rst_cause) |-> $past(mc_tick));

   // R6
   can_in_core_chk: assert property (@(posedge clk_osc) disable iff (!pwr_rst_n)
      can_rst |-> core_rst);

   // R7
   drive_in_core_chk: assert property (@(posedge clk_osc) disable iff (!pwr_rst_n)
      rst_pin_drive |-> core_rst);

   // R8
   drive_min_len_chk: assert property (@(posedge clk_osc) disable iff (!pwr_rst_n)
      $fell(rst_pin_drive) |-> (drv_mc >= WDT_MC));
endmodule

bind rsq_reset_seq rsq_reset_seq_chk #(.WDT_MC(WDT_MC)) u_rsq_chk (
   .clk_osc(clk_osc), .pwr_rst_n(pwr_rst_n), .mc_tick(mc_tick),
   .rst_pin_drive(rst_pin_drive), .core_rst(core_rst), .can_rst(can_rst),
   .rst_cause(rst_cause)
);

// File: tb/test_rsq_reset_seq.sv
`timescale 1ns/1ps
module test_rsq_reset_seq;
   localparam int OSC  = 12;
   localparam int QUAL = 2;
   localparam int WDTL = 3;
   localparam int WAKL = 6144;

   logic clk = 1'b0;
   logic pwr_rst_n = 1'b0;
   logic rst_pin_in = 1'b0, wdt_ovf = 1'b0, can_wake = 1'b0, pwr_down = 1'b0;
   logic mc_tick, rst_pin_drive, core_rst, can_rst, ale_hold, psen_hold;
   logic [1:0] rst_cause;

   int total = 0, bad = 0;
   bit done = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   rsq_reset_seq i_rsq_reset_seq (
      .clk_osc(clk), .pwr_rst_n(pwr_rst_n), .rst_pin_in(rst_pin_in),
      .wdt_ovf(wdt_ovf), .can_wake(can_wake), .pwr_down(pwr_down),
      .mc_tick(mc_tick), .rst_pin_drive(rst_pin_drive), .core_rst(core_rst),
      .can_rst(can_rst), .ale_hold(ale_hold), .psen_hold(psen_hold),
      .rst_cause(rst_cause)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference model
   int m_div, m_s1, m_s2, m_q, m_ext, m_wc, m_kc, m_wp, m_kp;
   int m_core, m_ctail, m_can, m_ntail, m_cause;

   always @(posedge clk or negedge pwr_rst_n) begin
      if (!pwr_rst_n) begin
         m_div = 0; m_s1 = 0; m_s2 = 0; m_q = 0; m_ext = 0;
         m_wc = 0; m_kc = 0; m_wp = 0; m_kp = 0;
         m_core = 1; m_ctail = 0; m_can = 1; m_ntail = 0; m_cause = 0;
      end else begin
         int fw, fk, q, e, nw, nk, src, cs;
         fw = (wdt_ovf || m_wp) ? 1 : 0;
         fk = ((can_wake && pwr_down) || m_kp) ? 1 : 0;
         if (m_div == OSC - 1) begin
            q  = m_s2 ? ((m_q < QUAL) ? m_q + 1 : m_q) : 0;
            e  = (q == QUAL) ? 1 : 0;
            nw = fw ? WDTL : ((m_wc > 0) ? m_wc - 1 : 0);
            nk = fk ? WAKL : ((m_kc > 0) ? m_kc - 1 : 0);
            src = (e || nw > 0 || nk > 0) ? 1 : 0;
            cs  = (e || nw > 0) ? 1 : 0;
            m_core = (src || m_ctail) ? 1 : 0; m_ctail = src;
            m_can  = (cs || m_ntail) ? 1 : 0;  m_ntail = cs;
            if (fk) m_cause = 3;
            else if (fw) m_cause = 2;
            else if (e && !m_ext) m_cause = 1;
            m_q = q; m_ext = e; m_wc = nw; m_kc = nk;
            m_wp = 0; m_kp = 0; m_div = 0;
         end else begin
            m_wp = fw; m_kp = fk; m_div = m_div + 1;
         end
         m_s2 = m_s1; m_s1 = rst_pin_in ? 1 : 0;
      end
   end

   // Per-clock comparison and window counters
   int n_core = 0, n_can = 0, n_drv = 0;
   always @(negedge clk) begin
      if (pwr_rst_n && !done) begin
         check(mc_tick == (m_div == OSC - 1), "R1", "mc_tick", mc_tick, m_div == OSC - 1);
         check(core_rst == m_core, "R7", "core_rst", core_rst, m_core);
         check(can_rst == m_can, "R6", "can_rst", can_rst, m_can);
         check(rst_pin_drive == (m_wc > 0 || m_kc > 0), "R4", "rst_pin_drive",
               rst_pin_drive, (m_wc > 0 || m_kc > 0));
         check(rst_cause == m_cause, "R10", "rst_cause", rst_cause, m_cause);
         check(ale_hold == m_core && psen_hold == m_core, "R9", "strobe hold",
               {ale_hold, psen_hold}, {m_core[0], m_core[0]});
         n_core += core_rst; n_can += can_rst; n_drv += rst_pin_drive;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         total++; bad++;
         $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 190000);
         finish_run();
      end
   end

   initial begin
      int c0, k0, d0;
      step(3);
      // R2: power-on state
      check(core_rst === 1'b1 && can_rst === 1'b1, "R2", "reset outputs high",
            {core_rst, can_rst}, 3);
      check(rst_cause === 2'b00, "R2", "cause at power-on", rst_cause, 0);
      pwr_rst_n = 1'b1;
      step(OSC - 1);
      check(core_rst == 1'b1, "R2", "core before first boundary", core_rst, 1);
      step(2);
      check(core_rst == 1'b0 && can_rst == 1'b0, "R2", "release after first boundary",
            {core_rst, can_rst}, 0);
      step(3 * OSC);

      // R3: short pin pulse covers at most one sample
      c0 = n_core;
      rst_pin_in = 1'b1; step(10); rst_pin_in = 1'b0;
      step(5 * OSC);
      check(n_core == c0, "R3", "short pin pulse ignored", n_core - c0, 0);
      check(rst_cause == 2'b00, "R3", "cause after short pulse", rst_cause, 0);

      // R3 / R10: long pin level is accepted
      rst_pin_in = 1'b1; step(5 * OSC);
      check(core_rst == 1'b1 && can_rst == 1'b1, "R3", "external reset",
            {core_rst, can_rst}, 3);
      check(rst_cause == 2'b01, "R10", "external cause", rst_cause, 1);
      rst_pin_in = 1'b0; step(6 * OSC);
      check(core_rst == 1'b0, "R7", "external released", core_rst, 0);
      check(rst_cause == 2'b01, "R10", "cause kept after release", rst_cause, 1);

      // R4 / R6: watchdog window
      c0 = n_core; k0 = n_can; d0 = n_drv;
      wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
      step(8 * OSC);
      check(n_drv - d0 == WDTL * OSC, "R4", "watchdog drive clocks", n_drv - d0, WDTL * OSC);
      check(n_can - k0 == (WDTL + 1) * OSC, "R6", "watchdog can_rst clocks",
            n_can - k0, (WDTL + 1) * OSC);
      check(n_core - c0 == (WDTL + 1) * OSC, "R7", "watchdog core clocks",
            n_core - c0, (WDTL + 1) * OSC);
      check(rst_cause == 2'b10, "R10", "watchdog cause", rst_cause, 2);

      // R5: wake outside power-down ignored
      d0 = n_drv; c0 = n_core;
      can_wake = 1'b1; step(1); can_wake = 1'b0;
      step(5 * OSC);
      check(n_drv == d0 && n_core == c0, "R5", "wake without power-down",
            n_drv - d0, 0);
      check(rst_cause == 2'b10, "R5", "cause unchanged by ignored wake", rst_cause, 2);

      // R5 / R6 / R8 / R10: wake window with same-boundary and nested watchdog
      c0 = n_core; k0 = n_can; d0 = n_drv;
      pwr_down = 1'b1;
      can_wake = 1'b1; wdt_ovf = 1'b1; step(1); can_wake = 1'b0; wdt_ovf = 1'b0;
      step(100 * OSC);
      check(rst_cause == 2'b11, "R10", "wake wins same boundary", rst_cause, 3);
      rst_pin_in = 1'b1; step(1); rst_pin_in = 1'b0;
      check(core_rst == 1'b1, "R7", "core held with pin low", core_rst, 1);
      wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
      step((WAKL + 10) * OSC);
      pwr_down = 1'b0;
      check(n_drv - d0 == WAKL * OSC, "R8", "wake drive not shortened",
            n_drv - d0, WAKL * OSC);
      check(n_core - c0 == (WAKL + 1) * OSC, "R5", "wake core clocks",
            n_core - c0, (WAKL + 1) * OSC);
      check(n_can - k0 == 2 * (WDTL + 1) * OSC, "R6", "can_rst only from watchdog",
            n_can - k0, 2 * (WDTL + 1) * OSC);
      check(rst_cause == 2'b10, "R10", "latest source recorded", rst_cause, 2);
      check(core_rst == 1'b0, "R11", "final release", core_rst, 0);
      finish_run();
   end
endmodule